// File: doc/BRIEF.md
# ATM cell header check byte generator and checker

This block produces and verifies the one-octet header error control field of an ATM cell. Header octets arrive one per valid cycle on a byte-wide stream, and a start strobe marks the first one. The block folds the first four octets into an 8-bit CRC remainder using x^8+x^2+x+1 (0x07), with the most significant bit first. It adds a programmable coset byte and presents the result as the fifth octet to transmit on the cycle after the fourth octet is accepted.

When a fifth octet follows on the same stream, the block treats it as a received check byte. It removes the coset that was captured for this header and completes the division over all forty bits. It then reports the resulting syndrome, with a flag that is high when the syndrome is zero. The coset is sampled only when a header starts, so software can rewrite it at any time without disturbing a header that is already in flight.

Top module: `hec_unit`

## Requirements
- R1: When `vld_i` and `sop_i` are both high, the remainder restarts from all zeros with that octet as header octet 0. This also applies while a previous header is incomplete, and that unfinished header is then discarded.
- R2: The accepted header octets 0..3 are divided by 0x07, MSB first, from a zero start. The remainder XOR the coset appears on `hec_o` with `hec_vld_o` high for exactly one cycle, in the cycle after octet 3 is accepted.
- R3: An all-zero header with coset 0x55 yields `hec_o` = 0x55.
- R4: The coset used for a header, both for generation and for checking, is the `coset_i` value at the start strobe. Later changes to `coset_i` have no effect on that header.
- R5: The next valid octet after octet 3, if `sop_i` is low, is the received check byte r. `syn_o` becomes the remainder of the 40-bit header (octets 0..3 followed by r XOR coset) divided by 0x07, and `syn_vld_o` is high for one cycle, in the cycle after r is accepted.
- R6: `hdr_ok_o` is high, with `syn_vld_o`, exactly when the reported syndrome is zero. It is low at all other times.
- R7: Cycles with `vld_i` low are ignored, and any number of them may occur between header octets.
- R8: Octets with `vld_i` high and `sop_i` low, when no header is open (after reset or after a check byte), produce no strobe.
- R9: After reset all outputs are zero.
- R10: `hec_o` and `syn_o` hold their last value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sop_i | input | 1 | Marks the current valid octet as header octet 0 |
| vld_i | input | 1 | Octet on `byte_i` is valid |
| byte_i | input | 8 | Header octet stream |
| coset_i | input | 8 | Programmable coset byte |
| hec_o | output | 8 | Generated check byte |
| hec_vld_o | output | 1 | One-cycle strobe for `hec_o` |
| syn_o | output | 8 | Syndrome of the last checked header |
| syn_vld_o | output | 1 | One-cycle strobe for `syn_o` |
| hdr_ok_o | output | 1 | Syndrome is zero (with `syn_vld_o`) |

## Verification
The case hardest to reach from the ports is a coset that changes while a header is open. That window lies between the start strobe and the check byte, and random idle gaps only sometimes stretch across it. Directed headers therefore drive the complement of the starting coset right after octet 0, and then expect both the generated byte and the syndrome to follow the old value. Random headers with random gaps, some with a deliberately corrupted check byte, cover the syndrome path against a bit-serial reference.

// File: rtl/hec_pkg.sv
package hec_pkg;
  localparam int unsigned OCT_W      = 8;
  localparam logic [7:0]  POLY_DEF   = 8'h07;
  localparam int unsigned HDR_OCT_DEF = 4;

  // one octet folded into the remainder, MSB first
  function automatic logic [OCT_W-1:0] crc_fold(input logic [OCT_W-1:0] rem,
                                                input logic [OCT_W-1:0] octet,
                                                input logic [OCT_W-1:0] poly);
    logic [OCT_W-1:0] r;
    r = rem ^ octet;
    for (int i = 0; i < OCT_W; i++) begin
      r = r[OCT_W-1] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/hec_ctrl.sv
module hec_ctrl
  import hec_pkg::*;
#(
  parameter int unsigned HDR_OCT = HDR_OCT_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sop_i,
  input  logic             vld_i,
  input  logic [OCT_W-1:0] coset_i,
  output logic             fold_o,
  output logic             first_o,
  output logic             last_o,
  output logic             chk_o,
  output logic [OCT_W-1:0] coset_o
);
  localparam int unsigned CNT_W = $clog2(HDR_OCT + 2);
  localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_OCT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OCT_W-1:0] coset_q;

  assign first_o = vld_i && sop_i;
  assign fold_o  = first_o || (vld_i && cnt_q != '0 && cnt_q < CNT_HDR);
  assign chk_o   = vld_i && !sop_i && cnt_q == CNT_HDR;
  assign last_o  = first_o ? (HDR_OCT == 1) : (fold_o && (cnt_q + 1'b1) == CNT_HDR);
  assign coset_o = first_o ? coset_i : coset_q;

  always_comb begin
    cnt_d = cnt_q;
    if (first_o)     cnt_d = CNT_W'(1);
    else if (fold_o) cnt_d = cnt_q + 1'b1;
    else if (chk_o)  cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      coset_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (first_o) coset_q <= coset_i;
    end
  end
endmodule

// File: rtl/hec_crc.sv
module hec_crc
  import hec_pkg::*;
#(
  parameter logic [OCT_W-1:0] POLY = POLY_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fold_i,
  input  logic             first_i,
  input  logic [OCT_W-1:0] byte_i,
  output logic [OCT_W-1:0] rem_o,
  output logic [OCT_W-1:0] rem_nxt_o
);
  logic [OCT_W-1:0] rem_q;

  assign rem_nxt_o = crc_fold(first_i ? '0 : rem_q, byte_i, POLY);
  assign rem_o     = rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (fold_i) rem_q <= rem_nxt_o;
  end
endmodule

// File: rtl/hec_out.sv
module hec_out
  import hec_pkg::*;
#(
  parameter logic [OCT_W-1:0] POLY = POLY_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             last_i,
  input  logic             chk_i,
  input  logic [OCT_W-1:0] rem_i,
  input  logic [OCT_W-1:0] rem_nxt_i,
  input  logic [OCT_W-1:0] byte_i,
  input  logic [OCT_W-1:0] coset_i,
  output logic [OCT_W-1:0] hec_o,
  output logic             hec_vld_o,
  output logic [OCT_W-1:0] syn_o,
  output logic             syn_vld_o,
  output logic             hdr_ok_o
);
  logic [OCT_W-1:0] syn_d;

  // strip coset from received byte, finish the 40-bit division
  assign syn_d = crc_fold(rem_i, byte_i ^ coset_i, POLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hec_o     <= '0;
      hec_vld_o <= 1'b0;
      syn_o     <= '0;
      syn_vld_o <= 1'b0;
      hdr_ok_o  <= 1'b0;
    end else begin
      hec_vld_o <= last_i;
      syn_vld_o <= chk_i;
      hdr_ok_o  <= chk_i && syn_d == '0;
      if (last_i) hec_o <= rem_nxt_i ^ coset_i;
      if (chk_i)  syn_o <= syn_d;
    end
  end
endmodule

// File: rtl/hec_unit.sv
module hec_unit
  import hec_pkg::*;
#(
  parameter logic [7:0]  POLY    = POLY_DEF,
  parameter int unsigned HDR_OCT = HDR_OCT_DEF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sop_i,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  input  logic [7:0] coset_i,
  output logic [7:0] hec_o,
  output logic       hec_vld_o,
  output logic [7:0] syn_o,
  output logic       syn_vld_o,
  output logic       hdr_ok_o
);
  logic             fold, first, last, chk;
  logic [OCT_W-1:0] coset_eff, rem, rem_nxt;

  hec_ctrl #(.HDR_OCT(HDR_OCT)) u_ctrl (
    .clk_i, .rst_ni, .sop_i, .vld_i, .coset_i,
    .fold_o(fold), .first_o(first), .last_o(last), .chk_o(chk), .coset_o(coset_eff)
  );

  hec_crc #(.POLY(POLY)) u_crc (
    .clk_i, .rst_ni, .fold_i(fold), .first_i(first), .byte_i,
    .rem_o(rem), .rem_nxt_o(rem_nxt)
  );

  hec_out #(.POLY(POLY)) u_out (
    .clk_i, .rst_ni, .last_i(last), .chk_i(chk), .rem_i(rem), .rem_nxt_i(rem_nxt),
    .byte_i, .coset_i(coset_eff),
    .hec_o, .hec_vld_o, .syn_o, .syn_vld_o, .hdr_ok_o
  );
endmodule

// File: rtl/hec_unit_chk.sv
module hec_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vld_i,
  input logic [7:0] hec_o,
  input logic       hec_vld_o,
  input logic [7:0] syn_o,
  input logic       syn_vld_o,
  input logic       hdr_ok_o
);
  // R6
  ok_means_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_ok_o |-> (syn_vld_o && syn_o == 8'h00));
  // R6
  zero_means_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syn_vld_o && syn_o == 8'h00) |-> hdr_ok_o);
  // R2
  hec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hec_vld_o |=> !hec_vld_o);
  // R5
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hec_vld_o, syn_vld_o}));
  // R10
  hec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hec_o) |-> hec_vld_o);
  // R10
  syn_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(syn_o) |-> syn_vld_o);
  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !(hec_vld_o || syn_vld_o));
endmodule

bind hec_unit hec_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .hec_o(hec_o), .hec_vld_o(hec_vld_o),
  .syn_o(syn_o), .syn_vld_o(syn_vld_o), .hdr_ok_o(hdr_ok_o)
);

// File: tb/sim_hec_unit.sv
`timescale 1ns/1ps
module sim_hec_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sop = 1'b0, vld = 1'b0;
  logic [7:0] byte_in = '0, coset = '0;
  logic [7:0] hec, syn;
  logic       hec_vld, syn_vld, ok;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  hec_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .sop_i(sop), .vld_i(vld), .byte_i(byte_in),
    .coset_i(coset), .hec_o(hec), .hec_vld_o(hec_vld), .syn_o(syn),
    .syn_vld_o(syn_vld), .hdr_ok_o(ok)
  );

  // bit-serial reference division, x^8+x^2+x+1
  function automatic logic [7:0] ref_crc(input logic [39:0] msg, input int nbits);
    logic [7:0] r = '0;
    logic fb;
    for (int i = nbits - 1; i >= 0; i--) begin
      fb = r[7] ^ msg[i];
      r  = r << 1;
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic octet(input logic [7:0] b, input logic s);
    @(negedge clk);
    vld = 1'b1; sop = s; byte_in = b;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b0; sop = 1'b0; byte_in = $urandom;
      @(posedge clk); #1;
      check("R7 idle strobe", {6'd0, hec_vld, syn_vld}, 8'h00);
    end
  endtask

  task automatic run_hdr(input logic [31:0] h, input logic [7:0] cs, input bit corrupt,
                         input int gap, input bit cs_change);
    logic [7:0] exp_hec, rx, exp_syn, held;
    exp_hec = ref_crc({8'h00, h}, 32) ^ cs;
    coset = cs;
    octet(h[31:24], 1'b1);
    if (cs_change) coset = ~cs;
    for (int k = 1; k < 4; k++) begin
      idle(gap);
      octet(h[31-8*k -: 8], 1'b0);
      if (k < 3) check("R2 early strobe", {7'd0, hec_vld}, 8'h00);
    end
    check("R2 hec_vld", {7'd0, hec_vld}, 8'h01);
    check(cs_change ? "R4 hec coset held" : "R2 hec value", hec, exp_hec);
    held = hec;
    idle(gap > 0 ? gap : 1);
    check("R10 hec hold", hec, held);
    rx = corrupt ? exp_hec ^ 8'($urandom_range(1, 255)) : exp_hec;
    exp_syn = ref_crc({h, rx ^ cs}, 40);
    octet(rx, 1'b0);
    check("R5 syn_vld", {7'd0, syn_vld}, 8'h01);
    check(cs_change ? "R4 syn coset held" : "R5 syndrome", syn, exp_syn);
    check("R6 hdr_ok", {7'd0, ok}, {7'd0, exp_syn == 8'h00});
    if (corrupt) check("R6 corrupt nonzero", {7'd0, syn != 8'h00}, 8'h01);
    idle(1);
    check("R10 syn hold", syn, exp_syn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4219));
    repeat (3) @(posedge clk);
    #1;
    // R9
    check("R9 reset hec", hec, 8'h00);
    check("R9 reset syn", syn, 8'h00);
    check("R9 reset strobes", {5'd0, hec_vld, syn_vld, ok}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // R8: stray octets with no open header
    for (int i = 0; i < 3; i++) begin
      octet(8'($urandom), 1'b0);
      check("R8 stray after reset", {6'd0, hec_vld, syn_vld}, 8'h00);
    end

    // R3
    run_hdr(32'h0000_0000, 8'h55, 1'b0, 0, 1'b0);
    check("R3 zero header", hec, 8'h55);

    // R8: stray after check byte
    for (int i = 0; i < 2; i++) begin
      octet(8'($urandom), 1'b0);
      check("R8 stray after check", {6'd0, hec_vld, syn_vld}, 8'h00);
    end

    // R1: abandoned header then restart
    octet(8'hA5, 1'b1);
    octet(8'h3C, 1'b0);
    octet(8'hFF, 1'b0);
    run_hdr(32'h0102_0304, 8'h55, 1'b0, 0, 1'b0);
    run_hdr(32'hFFFF_FFFF, 8'h00, 1'b1, 2, 1'b0);

    // R4: coset moves mid-header
    run_hdr(32'h1234_5678, 8'h55, 1'b0, 1, 1'b1);
    run_hdr(32'hDEAD_BEEF, 8'h9A, 1'b1, 0, 1'b1);

    // random mix, R2 R5 R6 R7
    for (int n = 0; n < 200; n++) begin
      run_hdr($urandom, 8'($urandom), ($urandom_range(0, 2) == 0),
              $urandom_range(0, 3), ($urandom_range(0, 3) == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule